// File: doc/BRIEF.md
# Compare and Capture Timer

A 16-bit up-counting timer that either measures events or generates a waveform. In output-compare mode two compare channels watch the running count. Each channel owns a 2-bit action that it applies to one shared compare output when its value is reached. The second channel can also restart the count from zero, which gives a programmable period. In input-capture mode the compares are inert. A rising edge on an already-filtered trigger input copies the count into a capture register.

Every compare match and every capture raises a sticky flag that stays set until it is cleared through a per-flag clear strobe. The control word is held inside the block. It is written through a simple write strobe and can be read back. The mode and reload fields only accept new values while counting is stopped. The reset input is asynchronous active-low; its release is synchronised inside the block and takes effect two clock edges after the port deasserts.

Top module: `cmp_cap_timer`

## Requirements
- R1: After reset the count, capture value, compare output, all three flags and the control word read zero. A zero control word means capture mode, no reload and hold actions.
- R2: While `cnt_en` is 1 the count rises by one on every clock edge, and it wraps from FFFFh to 0000h when reload is off. While `cnt_en` is 0 the count holds.
- R3: In compare mode, a clock edge with `cnt_en`=1 and count equal to `cmp0_val` applies the compare-0 action on that same edge. The action codes are 00 hold, 01 invert, 10 drive low and 11 drive high.
- R4: A compare-1 match applies the compare-1 action with the same encoding. When both channels match on the same edge, the compare-1 action decides the output.
- R5: In compare mode with the reload bit set, a compare-1 match loads 0000h into the count instead of incrementing it.
- R6: The control word has this layout: bit 0 mode (0 capture, 1 compare), bit 1 reload, bits 3:2 compare-0 action, bits 5:4 compare-1 action. A write takes effect one edge later. A write while `cnt_en`=1 keeps the old mode and reload bits and still updates the action fields.
- R7: Whenever the mode bit is 0, the reload bit and both action fields read 0. Compare matches then set no flag and leave the output unchanged.
- R8: In capture mode, a 0-to-1 change of `cap_trig` between two edges latches the count held before that edge into `cap_val`. A trigger held high does not capture again.
- R9: The flags are bit 0 compare-0, bit 1 compare-1 and bit 2 capture. Each stays set until its `flag_clr` bit is pulsed. A new event on the same edge as a clear wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable; 0 also unlocks mode and reload |
| cap_trig | input | 1 | Filtered capture trigger |
| cmp0_val | input | 16 | Compare-0 value |
| cmp1_val | input | 16 | Compare-1 value |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word write data |
| flag_clr | input | 3 | Per-flag clear strobes |
| count | output | 16 | Current count |
| cap_val | output | 16 | Last captured count |
| cmp_out | output | 1 | Compare output |
| flags | output | 3 | Sticky event flags |
| ctl_q | output | 6 | Current control word |

## Verification
Every result of this block is registered once. A control write, flag clear, compare action or capture is therefore due on the first edge after the inputs are presented. A count value is due exactly k edges after `cnt_en` rises. The bench drives inputs 2 ns after a rising edge and queues each expected value with its due edge number. A monitor compares it at the falling edge of that cycle, and an item found past its due edge is reported as a failure. The wrap check waits the full 65536 edges, so that case is timed precisely as well.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned N_CMP  = 2;
  localparam int unsigned N_FLAG = N_CMP + 1;
  localparam int unsigned FLAG_CAP = N_CMP;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;

  typedef struct packed {
    act_e act1;
    act_e act0;
    logic reload;
    logic mode;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

  function automatic logic apply_act(input act_e act, input logic cur);
    case (act)
      ACT_TOGGLE: apply_act = ~cur;
      ACT_LOW:    apply_act = 1'b0;
      ACT_HIGH:   apply_act = 1'b1;
      default:    apply_act = cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_ctrl_reg.sv
`timescale 1ns/1ps
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  input  logic we,
  input  ctl_t wdata,
  output ctl_t ctl
);
  ctl_t ctl_d;
  ctl_t ctl_r;

  always_comb begin
    ctl_d = ctl_r;
    if (we) begin
      ctl_d.act0 = wdata.act0;
      ctl_d.act1 = wdata.act1;
      if (!cnt_en) begin
        ctl_d.mode   = wdata.mode;
        ctl_d.reload = wdata.reload;
      end
      if (!ctl_d.mode) begin
        ctl_d.reload = 1'b0;
        ctl_d.act0   = ACT_HOLD;
        ctl_d.act1   = ACT_HOLD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_r <= '0;
    else if (we) ctl_r <= ctl_d;
  end

  assign ctl = ctl_r;
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] STEP = W'(1);
  logic [W-1:0] cnt_r;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_r;
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_r + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_r <= '0;
    else if (cnt_en) cnt_r <= cnt_d;
  end

  assign cnt = cnt_r;
endmodule

// File: rtl/tmr_cmp_unit.sv
`timescale 1ns/1ps
module tmr_cmp_unit
  import tmr_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned NC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 armed,
  input  logic [W-1:0]         cnt,
  input  logic [NC-1:0][W-1:0] cmp_vals,
  input  act_e [NC-1:0]        acts,
  input  logic [NC-1:0]        clr,
  output logic [NC-1:0]        hit,
  output logic [NC-1:0]        flag,
  output logic                 out
);
  logic [NC-1:0] flag_r;
  logic [NC-1:0] flag_d;
  logic          out_r;
  logic          out_d;

  for (genvar i = 0; i < NC; i++) begin : g_chan
    assign hit[i]    = armed && (cnt == cmp_vals[i]);
    assign flag_d[i] = hit[i] | (flag_r[i] & ~clr[i]);
  end

  // Higher channel index is applied last and so wins on a shared edge.
  always_comb begin
    out_d = out_r;
    for (int i = 0; i < NC; i++) begin
      if (hit[i]) out_d = apply_act(acts[i], out_r);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_r <= '0;
      out_r  <= 1'b0;
    end else begin
      flag_r <= flag_d;
      out_r  <= out_d;
    end
  end

  assign flag = flag_r;
  assign out  = out_r;
endmodule

// File: rtl/tmr_capture.sv
`timescale 1ns/1ps
module tmr_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         trig,
  input  logic [W-1:0] cnt,
  input  logic         clr,
  output logic [W-1:0] cap,
  output logic         flag
);
  logic         trig_r;
  logic [W-1:0] cap_r;
  logic [W-1:0] cap_d;
  logic         flag_r;
  logic         flag_d;
  logic         take;

  always_comb begin
    take   = enable && trig && !trig_r;
    cap_d  = take ? cnt : cap_r;
    flag_d = take | (flag_r & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_r <= 1'b0;
      cap_r  <= '0;
      flag_r <= 1'b0;
    end else begin
      trig_r <= trig;
      cap_r  <= cap_d;
      flag_r <= flag_d;
    end
  end

  assign cap  = cap_r;
  assign flag = flag_r;
endmodule

// File: rtl/cmp_cap_timer.sv
`timescale 1ns/1ps
module cmp_cap_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              cap_trig,
  input  logic [W-1:0]      cmp0_val,
  input  logic [W-1:0]      cmp1_val,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic [N_FLAG-1:0] flag_clr,
  output logic [W-1:0]      count,
  output logic [W-1:0]      cap_val,
  output logic              cmp_out,
  output logic [N_FLAG-1:0] flags,
  output logic [CTL_W-1:0]  ctl_q
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  ctl_t                    ctl;
  logic [N_CMP-1:0][W-1:0] cmp_vals;
  act_e [N_CMP-1:0]        acts;
  logic [N_CMP-1:0]        hit;
  logic [N_CMP-1:0]        cmp_flag;
  logic                    cap_flag;
  logic                    armed;
  logic                    restart;

  assign cmp_vals = {cmp1_val, cmp0_val};
  assign acts     = {ctl.act1, ctl.act0};
  assign armed    = cnt_en && ctl.mode;
  assign restart  = hit[1] && ctl.reload;

  tmr_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .cnt_en (cnt_en),
    .we     (ctl_we),
    .wdata  (ctl_t'(ctl_wdata)),
    .ctl    (ctl)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cnt_en  (cnt_en),
    .restart (restart),
    .cnt     (count)
  );

  tmr_cmp_unit #(.W(W), .NC(N_CMP)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .armed    (armed),
    .cnt      (count),
    .cmp_vals (cmp_vals),
    .acts     (acts),
    .clr      (flag_clr[N_CMP-1:0]),
    .hit      (hit),
    .flag     (cmp_flag),
    .out      (cmp_out)
  );

  tmr_capture #(.W(W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .enable (!ctl.mode),
    .trig   (cap_trig),
    .cnt    (count),
    .clr    (flag_clr[FLAG_CAP]),
    .cap    (cap_val),
    .flag   (cap_flag)
  );

  assign flags = {cap_flag, cmp_flag};
  assign ctl_q = ctl;
endmodule

// File: rtl/cmp_cap_timer_chk.sv
`timescale 1ns/1ps
module cmp_cap_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic [W-1:0] cmp1_val,
  input logic [2:0]   flag_clr,
  input logic [W-1:0] count,
  input logic [W-1:0] cap_val,
  input logic         cmp_out,
  input logic [2:0]   flags,
  input logic [5:0]   ctl_q
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && !ctl_q[1] |=> count == $past(count) + W'(1));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && ctl_q[0] && ctl_q[1] && count == cmp1_val |=> count == '0);

  p_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && ctl_q[0] && count == cmp1_val && ctl_q[5:4] == 2'b11 |=> cmp_out);

  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> ctl_q[1:0] == $past(ctl_q[1:0]));

  p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |-> ctl_q[5:1] == '0);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |=> $stable(cmp_out));

  p_nocap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0] |=> $stable(cap_val));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] && !flag_clr[0] |=> flags[0]);
endmodule

bind cmp_cap_timer cmp_cap_timer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .cnt_en   (cnt_en),
  .cmp1_val (cmp1_val),
  .flag_clr (flag_clr),
  .count    (count),
  .cap_val  (cap_val),
  .cmp_out  (cmp_out),
  .flags    (flags),
  .ctl_q    (ctl_q)
);

// File: tb/cmp_cap_timer_test.sv
`timescale 1ns/1ps
module cmp_cap_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en;
  logic        cap_trig;
  logic [15:0] cmp0_val;
  logic [15:0] cmp1_val;
  logic        ctl_we;
  logic [5:0]  ctl_wdata;
  logic [2:0]  flag_clr;
  logic [15:0] count;
  logic [15:0] cap_val;
  logic        cmp_out;
  logic [2:0]  flags;
  logic [5:0]  ctl_q;

  always #5 clk = ~clk;

  cmp_cap_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_trig(cap_trig),
    .cmp0_val(cmp0_val), .cmp1_val(cmp1_val), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .flag_clr(flag_clr), .count(count),
    .cap_val(cap_val), .cmp_out(cmp_out), .flags(flags), .ctl_q(ctl_q)
  );

  localparam int K_CNT = 0, K_CAP = 1, K_OUT = 2, K_FLG = 3, K_CTL = 4;

  typedef struct {
    int          due;
    int          kind;
    logic [15:0] val;
    string       req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares queued expectations at the falling edge of their due cycle.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        K_CNT:   act = count;
        K_CAP:   act = cap_val;
        K_OUT:   act = {15'd0, cmp_out};
        K_FLG:   act = {13'd0, flags};
        default: act = {10'd0, ctl_q};
      endcase
      n_chk++;
      if (it.due < cyc) begin
        n_bad++;
        $display("FAIL %s kind %0d missed its cycle: actual %h expected %h", it.req, it.kind, act, it.val);
      end else if (act !== it.val) begin
        n_bad++;
        $display("FAIL %s kind %0d: actual %h expected %h", it.req, it.kind, act, it.val);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic expect_at(input int kind, input logic [15:0] val, input int d, input string req);
    item_t it;
    it.due = cyc + d; it.kind = kind; it.val = val; it.req = req;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() > 0) tick(1);
  endtask

  task automatic do_reset();
    drain();
    rst_n = 1'b0; cnt_en = 1'b0; cap_trig = 1'b0; ctl_we = 1'b0;
    ctl_wdata = '0; flag_clr = '0; cmp0_val = '0; cmp1_val = '0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic write_ctl(input logic [5:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    tick(1);
    ctl_we = 1'b0;
  endtask

  task automatic pulse_clr(input logic [2:0] m);
    flag_clr = m;
    tick(1);
    flag_clr = '0;
  endtask

  initial begin
    #(10 * 199000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // Scenario A: reset state, stopped write, compare-0 set, compare-1 clear with reload.
    do_reset();
    expect_at(K_CNT, 16'h0, 0, "R1 count");
    expect_at(K_CAP, 16'h0, 0, "R1 cap_val");
    expect_at(K_OUT, 16'h0, 0, "R1 cmp_out");
    expect_at(K_FLG, 16'h0, 0, "R1 flags");
    expect_at(K_CTL, 16'h0, 0, "R1 ctl_q");
    cmp0_val = 16'd5; cmp1_val = 16'd10;
    expect_at(K_CTL, 16'h2F, 1, "R6 write while stopped");
    expect_at(K_CNT, 16'h0, 1, "R2 hold while stopped");
    write_ctl(6'h2F);
    cnt_en = 1'b1;
    expect_at(K_CNT, 16'd6, 6, "R2 count step");
    expect_at(K_OUT, 16'h1, 6, "R3 compare-0 drive high");
    expect_at(K_FLG, 16'h1, 6, "R3 compare-0 flag");
    expect_at(K_CNT, 16'd0, 11, "R5 reload on compare-1");
    expect_at(K_OUT, 16'h0, 11, "R4 compare-1 drive low");
    expect_at(K_FLG, 16'h3, 11, "R9 both flags sticky");
    expect_at(K_CNT, 16'd1, 12, "R5 count resumes after reload");
    tick(11);
    expect_at(K_CTL, 16'h17, 1, "R6 running write keeps mode/reload");
    write_ctl(6'h14);
    expect_at(K_FLG, 16'h2, 1, "R9 clear compare-0 flag only");
    pulse_clr(3'b001);
    drain();

    // Scenario B: simultaneous match, compare-1 wins.
    do_reset();
    cmp0_val = 16'd3; cmp1_val = 16'd3;
    write_ctl(6'h39);
    cnt_en = 1'b1;
    expect_at(K_OUT, 16'h1, 4, "R4 compare-1 priority");
    expect_at(K_FLG, 16'h3, 4, "R4 both matched");
    tick(5);
    drain();

    // Scenario C: toggle and wrap without reload.
    do_reset();
    cmp0_val = 16'd2; cmp1_val = 16'hFFFF;
    write_ctl(6'h05);
    cnt_en = 1'b1;
    expect_at(K_OUT, 16'h1, 3, "R3 toggle");
    expect_at(K_FLG, 16'h1, 3, "R3 flag after toggle");
    expect_at(K_CNT, 16'h0, 65536, "R2 wrap to zero");
    expect_at(K_FLG, 16'h3, 65536, "R4 compare-1 flag at FFFFh");
    expect_at(K_CNT, 16'd3, 65539, "R2 count after wrap");
    expect_at(K_OUT, 16'h0, 65539, "R3 second toggle");
    tick(65540);
    drain();

    // Scenario D: capture mode.
    do_reset();
    cmp0_val = 16'd2; cmp1_val = 16'd4;
    expect_at(K_CTL, 16'h0, 1, "R7 fields forced in capture mode");
    write_ctl(6'h3E);
    cnt_en = 1'b1;
    tick(5);
    cap_trig = 1'b1;
    expect_at(K_CAP, 16'd5, 1, "R8 capture on rising trigger");
    expect_at(K_FLG, 16'h4, 1, "R8 capture flag");
    expect_at(K_CAP, 16'd5, 4, "R8 held trigger no recapture");
    expect_at(K_OUT, 16'h0, 4, "R7 output untouched");
    expect_at(K_FLG, 16'h4, 4, "R7 no compare flags");
    tick(4);
    cap_trig = 1'b0;
    tick(1);
    expect_at(K_FLG, 16'h0, 1, "R9 clear capture flag");
    pulse_clr(3'b100);
    cap_trig = 1'b1; flag_clr = 3'b100;
    expect_at(K_FLG, 16'h4, 1, "R9 set wins over clear");
    expect_at(K_CAP, 16'd11, 1, "R8 second capture");
    tick(1);
    flag_clr = '0; cap_trig = 1'b0;
    drain();

    // Scenario E: mode lock while running.
    do_reset();
    cnt_en = 1'b1;
    expect_at(K_CTL, 16'h0, 1, "R6 mode write ignored while running");
    write_ctl(6'h3F);
    cnt_en = 1'b0;
    expect_at(K_CNT, 16'd1, 1, "R2 hold after stop");
    tick(1);
    expect_at(K_CTL, 16'h3F, 1, "R6 mode write accepted when stopped");
    expect_at(K_CNT, 16'd1, 1, "R2 still holding");
    write_ctl(6'h3F);
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule